// File: doc/BRIEF.md
# Serial-Loaded DAC Code Register

This block is the digital front end of a 16-bit digital-to-analog converter that is loaded over a three-wire serial link: a serial clock, a serial data line and an active-low select line that doubles as the load strobe. While select is low, every rising edge of the serial clock shifts one data bit into a shift register, most significant bit first. When select returns high, the assembled word is copied into the converter's code register, and the code output changes.

All three serial inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the block finds edges on the synchronized copies. The system clock must run at least four times the serial clock rate, with each serial clock level held for at least two system cycles. The top bit of the shift register is driven out as a serial output. Several devices can therefore be chained, each one's serial output feeding the next one's data input, on a shared clock and select.

The code output has no back-pressure. `code_stb_o` is a one-cycle valid pulse on the cycle a new code appears, and there is no ready: the converter always accepts a new code. A word is loaded even when the number of shifted bits was not a multiple of 16, and that case is flagged with a pulse.

Top module: `sdac_input_reg`

## Requirements
- R1: While select is low, each rising edge of the serial clock shifts the data bit into bit 0 of the shift register, and the older bits move one place toward bit 15. A 16-bit word sent most significant bit first therefore loads as the same value.
- R2: Serial clock edges that occur while select is high leave the shift register unchanged.
- R3: A low-to-high transition of select copies the shift register into `code_o`. `code_o` holds its value at all other times.
- R4: A serial clock that is already high when select falls does not count as an edge. Only a low-to-high serial clock transition seen while select is low shifts a bit.
- R5: `chain_o` is bit 15 of the shift register. It shows the previous word's bit 15 before the first shift, and after 16 further shifts it shows the new word's bit 15.
- R6: `code_stb_o` is high for exactly one cycle: the cycle on which `code_o` takes a newly loaded value.
- R7: At a load, `count_err_o` pulses together with `code_stb_o` when the number of bits shifted since the previous load is not a multiple of 16. The load still takes the current register contents. Zero, 16 or 32 bits give no flag.
- R8: Reset clears the shift register and `code_o` to zero, with `chain_o`, `code_stb_o` and `count_err_o` low.
- R9: Each result appears on the third rising system clock edge after the input change that causes it: two synchronizer stages, then the registered update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, sampled on a qualified serial clock rise |
| sel_n_i | input | 1 | Active-low select; its rising edge loads the code |
| code_o | output | 16 | Converter code register |
| code_stb_o | output | 1 | One-cycle valid pulse when code_o is written |
| count_err_o | output | 1 | One-cycle flag: the loaded bit count was not a multiple of 16 |
| chain_o | output | 1 | Shift register bit 15, for chaining devices |

## Verification
Every output moves on the third rising system edge after the serial input change that caused it. A load pulse is therefore due three edges after select rises, and `chain_o` three edges after a serial clock rise. A behavioural model in the bench delays the sampled inputs by the same amount and is compared against all four outputs on every falling edge. The scenario checks count falling edges from the stimulus: they confirm that the strobe is absent at the first and second edges and present at the third, and they read the code and chain values only after the pipeline has settled.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned SDAC_SYNC_STAGES = 2;

  typedef struct packed {
    logic shift;   // qualified serial clock rise
    logic commit;  // select rising edge
    logic bit_in;  // synchronized serial data
  } sdac_evt_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned N       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
  import sdac_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_s_i,
  input  logic      sel_n_s_i,
  input  logic      din_s_i,
  output sdac_evt_t evt_o
);
  logic sclk_d, sel_n_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      sel_n_d <= 1'b1;
    end else begin
      sclk_d  <= sclk_s_i;
      sel_n_d <= sel_n_s_i;
    end
  end

  // A serial clock edge counts only as a true low-to-high step while select is low.
  assign evt_o.shift  = sclk_s_i & ~sclk_d & ~sel_n_s_i;
  assign evt_o.commit = sel_n_s_i & ~sel_n_d;
  assign evt_o.bit_in = din_s_i;

  // R4: a qualified shift needs the serial clock to have been low one cycle earlier
  p_shift_from_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.shift |-> !$past(sclk_s_i));
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  localparam int unsigned CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sdac_evt_t        evt_i,
  output logic [WIDTH-1:0] word_o,
  output logic             partial_o
);
  logic [WIDTH-1:0] word_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (evt_i.shift) begin
      word_q <= {word_q[WIDTH-2:0], evt_i.bit_in};
    end
  end

  // Bits shifted since the last load, modulo WIDTH.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (evt_i.commit) begin
      cnt_q <= '0;
    end else if (evt_i.shift) begin
      if (cnt_q == CNT_W'(WIDTH-1)) cnt_q <= '0;
      else                          cnt_q <= cnt_q + 1'b1;
    end
  end

  assign word_o    = word_q;
  assign partial_o = (cnt_q != '0);

  // R2: no qualified edge, no movement in the shift register
  p_hold_without_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i.shift |=> $stable(word_q));
  // R1: the newest bit lands at bit 0
  p_msb_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i.shift |=> (word_q[0] == $past(evt_i.bit_in)));
endmodule

// File: rtl/sdac_input_reg.sv
module sdac_input_reg
  import sdac_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             sdata_i,
  input  logic             sel_n_i,
  output logic [WIDTH-1:0] code_o,
  output logic             code_stb_o,
  output logic             count_err_o,
  output logic             chain_o
);
  logic [2:0]       raw, synced;
  sdac_evt_t        evt;
  logic [WIDTH-1:0] word;
  logic             partial;

  assign raw = {sel_n_i, sclk_i, sdata_i};

  sdac_sync #(.N(3), .STAGES(SDAC_SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(synced)
  );

  sdac_edge u_edge (
    .clk(clk), .rst_n(rst_n),
    .sclk_s_i(synced[1]), .sel_n_s_i(synced[2]), .din_s_i(synced[0]),
    .evt_o(evt)
  );

  sdac_shift #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .word_o(word), .partial_o(partial)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o      <= '0;
      code_stb_o  <= 1'b0;
      count_err_o <= 1'b0;
    end else begin
      code_stb_o  <= evt.commit;
      count_err_o <= evt.commit & partial;
      if (evt.commit) code_o <= word;
    end
  end

  assign chain_o = word[WIDTH-1];

  // R6: the code moves only on a strobe cycle
  p_code_moves_with_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o != $past(code_o)) |-> code_stb_o);
  // R6: the strobe lasts one cycle
  p_stb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    code_stb_o |=> !code_stb_o);
  // R7: the count flag rides on a load
  p_err_with_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count_err_o |-> code_stb_o);
  // R3: a load copies the shift register
  p_load_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
    code_stb_o |-> (code_o == $past(word)));
endmodule

// File: tb/sdac_input_reg_test.sv
`timescale 1ns/1ps
module sdac_input_reg_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sel_n = 1'b1;
  logic [15:0] code;
  logic code_stb, count_err, chain;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  sdac_input_reg uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sel_n_i(sel_n),
    .code_o(code), .code_stb_o(code_stb), .count_err_o(count_err), .chain_o(chain)
  );

  // Behavioural reference: input history queues, three-edge latency.
  logic qs[$], qd[$], qn[$];
  logic [15:0] m_shift, m_code;
  int m_cnt;
  logic m_stb, m_err;

  task automatic model_reset();
    qs = {1'b0, 1'b0, 1'b0, 1'b0};
    qd = {1'b0, 1'b0, 1'b0, 1'b0};
    qn = {1'b1, 1'b1, 1'b1, 1'b1};
    m_shift = 16'h0; m_code = 16'h0; m_cnt = 0; m_stb = 1'b0; m_err = 1'b0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
    end else begin
      logic rise, load;
      qs.push_back(sclk); qd.push_back(sdata); qn.push_back(sel_n);
      void'(qs.pop_front()); void'(qd.pop_front()); void'(qn.pop_front());
      rise = qs[1] && !qs[0] && !qn[1];
      load = qn[1] && !qn[0];
      m_stb = 1'b0; m_err = 1'b0;
      if (rise) begin
        m_shift = {m_shift[14:0], qd[1]};
        m_cnt = (m_cnt + 1) % 16;
      end
      if (load) begin
        m_code = m_shift; m_stb = 1'b1; m_err = (m_cnt != 0); m_cnt = 0;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 code", 32'(code), 32'(m_code));
      check("R6 strobe", 32'(code_stb), 32'(m_stb));
      check("R7 count flag", 32'(count_err), 32'(m_err));
      check("R5 chain", 32'(chain), 32'(m_shift[15]));
    end
  end

  int stb_seen = 0, err_seen = 0;
  always @(posedge clk) begin
    if (rst_n && code_stb) stb_seen++;
    if (rst_n && count_err) err_seen++;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk); sclk = 1'b0; sdata = b;
    idle(2); sclk = 1'b1;
    idle(2); sclk = 1'b0;
  endtask

  task automatic send_bits(logic [31:0] w, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic load();
    @(negedge clk); sel_n = 1'b1;
    idle(5);
    @(negedge clk); sel_n = 1'b0;
    idle(3);
  endtask

  initial begin
    idle(3);
    check("R8 reset code", 32'(code), 0);
    check("R8 reset chain", 32'(chain), 0);
    check("R8 reset strobe", 32'(code_stb), 0);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    @(negedge clk); sel_n = 1'b0;
    idle(3);

    // R1, R3, R6, R9: first word, and the load latency
    send_bits(32'hA5C3, 16);
    idle(3);
    check("R3 code held before load", 32'(code), 0);
    @(negedge clk); sel_n = 1'b1;
    @(negedge clk); check("R9 no strobe at edge 1", 32'(code_stb), 0);
    @(negedge clk); check("R9 no strobe at edge 2", 32'(code_stb), 0);
    @(negedge clk); check("R9 strobe at edge 3", 32'(code_stb), 1);
    check("R1 word loaded MSB first", 32'(code), 32'hA5C3);
    check("R7 full word no flag", 32'(count_err), 0);
    @(negedge clk); check("R6 strobe one cycle", 32'(code_stb), 0);
    check("R6 one strobe counted", 32'(stb_seen), 1);

    // R2: serial clock toggles with select high
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    idle(3);
    check("R2 chain unchanged", 32'(chain), 1);
    @(negedge clk); sel_n = 1'b0;
    idle(4);
    load();
    check("R2 reload unchanged", 32'(code), 32'hA5C3);
    check("R7 zero bits no flag", 32'(err_seen), 0);

    // R4: serial clock already high when select falls
    @(negedge clk); sel_n = 1'b1; sclk = 1'b1; sdata = 1'b0;
    idle(4);
    @(negedge clk); sel_n = 1'b0;
    idle(4);
    @(negedge clk); sclk = 1'b0;
    idle(4);
    load();
    check("R4 no spurious shift", 32'(code), 32'hA5C3);
    check("R4 no count flag", 32'(err_seen), 0);

    // R5: chain output walks out the old word
    send_bits(32'hC2B1, 16);
    load();
    check("R5 chain shows old D15", 32'(chain), 1);
    for (int k = 1; k <= 16; k++) begin
      logic [31:0] nw;
      logic expb;
      nw = 32'h8000;
      send_bit(nw[16-k]);
      idle(3);
      expb = (k < 16) ? 1'(32'hC2B1 >> (15 - k)) : 1'b1;
      check("R5 chain sequence", 32'(chain), 32'(expb));
    end
    load();
    check("R5 new word loaded", 32'(code), 32'h8000);

    // R7: short transfer still loads and flags
    send_bits(32'h16, 5);
    idle(3);
    @(negedge clk); sel_n = 1'b1;
    idle(3);
    check("R7 partial flag", 32'(count_err), 1);
    check("R7 partial contents", 32'(code), 32'h0016);
    idle(3);
    @(negedge clk); sel_n = 1'b0;
    idle(3);

    // R7: 32 bits leave the last word and no flag
    send_bits(32'hDEADBEEF, 32);
    load();
    check("R7 32 bits code", 32'(code), 32'hBEEF);
    check("R7 32 bits no extra flag", 32'(err_seen), 1);

    // R8: reset in mid-operation
    send_bits(32'h7, 3);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R8 reset clears code", 32'(code), 0);
    check("R8 reset clears chain", 32'(chain), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule